// File: doc/BRIEF.md
# I2C Master Bus-Access Front End with Bounded Clock-Stretch Wait

This block is the part of an I2C master that touches the wires. Before a START it confirms that the bus is free. It then produces the START condition. Whenever it lets the clock line go, it waits for a slave that holds the clock low, but only for a bounded time. An unpowered or dead slave that pins SCL low therefore ends in an error report and not in a hung controller. Both lines are driven as open-drain pull-down enables. Both are read back through two-register synchronizers.

The host issues one of two requests. A start request runs the idle check and generates the START. A clock-release request produces the high half of one bit clock: it lets SCL go, waits until SCL is seen high, keeps it high for the setup time, then pulls it low again. Every request ends with a one-cycle done pulse. On failure one of two sticky error flags is also set: the data line stuck low, or the stretch wait timed out. The timeout and the SDA-to-SCL setup time are parameters counted in system clock cycles. Byte shifting, acknowledge handling, STOP generation and multi-master arbitration are handled elsewhere.

Top module: `i2c_bus_front`

## Requirements
- R1: When a request is accepted in idle, the next cycle shows the SCL enable released (0). A start request also releases the SDA enable. Both error flags clear on that same edge.
- R2: For a start request, if synchronized SDA reads low three cycles after acceptance, `err_stuck` is set and `done` pulses in that cycle. Both enables are 0. No START is produced. Seen from the host, done appears 4 cycles after the request edge.
- R3: If synchronized SCL reads low at the check, the block waits for it to go high and does not drive SDA while waiting. It then continues normally with no error.
- R4: A stretch wait ends with `err_timeout` after TIMEOUT_CYC cycles. On that edge `done` pulses and both enables are released. For a wait that begins at the check, done is seen TIMEOUT_CYC+4 cycles after the request edge.
- R5: A START pulls SDA low (`sda_oe`=1) first. SCL follows (`scl_oe`=1) exactly SETUP_CYC cycles later. With no stretching, done is seen SETUP_CYC+4 cycles after the request edge.
- R6: A clock-release request uses the same check and timed wait on SCL. Once SCL is high, it keeps SCL released for SETUP_CYC cycles and then pulls it low together with `done`. It never changes `sda_oe` on success; with no stretching, done is seen SETUP_CYC+4 cycles after the request edge.
- R7: Line levels reach the decision logic only through a two-register synchronizer. A request is judged on the lines three cycles after acceptance.
- R8: `done` is a single-cycle pulse. Exactly one pulse is produced per accepted request, on success and on failure alike.
- R9: Error flags hold their value while idle until the next accepted request. At most one of them is set at a time.
- R10: Requests that arrive while the block is busy are ignored. A start and a release request in the same idle cycle are treated as a start.
- R11: After reset both enables are 0, `done`, `busy` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request: idle check and START generation |
| rel_req | input | 1 | Request: one timed high phase of SCL |
| sda_in | input | 1 | SDA line level as read from the pad |
| scl_in | input | 1 | SCL line level as read from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 leaves it undriven |
| scl_oe | output | 1 | 1 pulls SCL low, 0 leaves it undriven |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of each request |
| err_stuck | output | 1 | SDA was low at the idle check (sticky) |
| err_timeout | output | 1 | SCL stayed low longer than the timeout (sticky) |

## Verification
The assertions assume that requests are single-cycle pulses. They also assume that the line inputs are the wired-AND of the block's own enables and a slave model, so SCL can only read high when `scl_oe` is 0. The bench forms both pad inputs exactly that way. Its slave model can only hold SCL low until a chosen cycle or hold SDA low. Requests are driven on the falling edge, and each request is given time to finish before the next one is raised, except in the test that deliberately sends a request while the block is busy.

// File: rtl/i2c_bus_front.sv
module i2c_bus_front #(
  parameter int TIMEOUT_CYC = 2_500_000,
  parameter int SETUP_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic rel_req,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_oe,
  output logic scl_oe,
  output logic busy,
  output logic done,
  output logic err_stuck,
  output logic err_timeout
);
  localparam int MAXC = ((TIMEOUT_CYC > SETUP_CYC) ? TIMEOUT_CYC : SETUP_CYC) + 4;
  localparam int CW   = $clog2(MAXC);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] SY_LAST = CW'(2);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_STRETCH, S_SDA_LO, S_SCL_HI} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          op_start;
  logic [1:0]    sda_q, scl_q;
  logic          sda_s, scl_s;

  assign sda_s = sda_q[1];
  assign scl_s = scl_q[1];
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 2'b11;
      scl_q <= 2'b11;
    end else begin
      sda_q <= {sda_q[0], sda_in};
      scl_q <= {scl_q[0], scl_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      op_start    <= 1'b0;
      sda_oe      <= 1'b0;
      scl_oe      <= 1'b0;
      done        <= 1'b0;
      err_stuck   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_req || rel_req) begin
            op_start    <= start_req;
            scl_oe      <= 1'b0;
            if (start_req) sda_oe <= 1'b0;
            err_stuck   <= 1'b0;
            err_timeout <= 1'b0;
            cnt         <= '0;
            state       <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (cnt != SY_LAST) begin
            cnt <= cnt + 1'b1;
          end else if (op_start && !sda_s) begin
            err_stuck <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else if (!scl_s) begin
            cnt   <= '0;
            state <= S_STRETCH;
          end else begin
            cnt <= '0;
            if (op_start) begin
              sda_oe <= 1'b1;
              state  <= S_SDA_LO;
            end else begin
              state  <= S_SCL_HI;
            end
          end
        end
        S_STRETCH: begin
          if (scl_s) begin
            cnt <= '0;
            if (op_start) begin
              sda_oe <= 1'b1;
              state  <= S_SDA_LO;
            end else begin
              state  <= S_SCL_HI;
            end
          end else if (cnt == TO_LAST) begin
            err_timeout <= 1'b1;
            done        <= 1'b1;
            sda_oe      <= 1'b0;
            scl_oe      <= 1'b0;
            state       <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SDA_LO, S_SCL_HI: begin
          if (cnt == SU_LAST) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_release_on_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && (start_req || rel_req)) |=> !scl_oe);

  p_start_frees_sda_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_req) |=> (!sda_oe && op_start));

  p_stuck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_stuck) |-> (!sda_oe && !scl_oe && done));

  p_stretch_no_sda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRETCH && op_start) |-> !sda_oe);

  p_wait_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRETCH) |-> (cnt <= TO_LAST));

  p_timeout_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (!sda_oe && !scl_oe && done));

  p_sda_before_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SDA_LO) |-> (sda_oe && !scl_oe));

  p_rel_keeps_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCL_HI && !op_start) |-> $stable(sda_oe));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start_req && !rel_req) |=> $stable({err_stuck, err_timeout}));

  p_one_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_stuck && err_timeout));
endmodule

// File: tb/i2c_bus_front_bench.sv
module i2c_bus_front_bench;
  localparam int TO = 40;
  localparam int SU = 3;
  localparam int FOREVER = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, rel_req = 1'b0;
  logic slave_sda_low = 1'b0;
  int   hold_until = 0;
  int   cyc_ctr = 0;
  logic sda_in, scl_in, sda_oe, scl_oe, busy, done, err_stuck, err_timeout;
  int   checks = 0, failures = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc_ctr <= cyc_ctr + 1;

  assign sda_in = !sda_oe && !slave_sda_low;
  assign scl_in = !scl_oe && (cyc_ctr >= hold_until);

  i2c_bus_front #(.TIMEOUT_CYC(TO), .SETUP_CYC(SU)) u_i2c_bus_front (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rel_req(rel_req),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .busy(busy), .done(done), .err_stuck(err_stuck), .err_timeout(err_timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        is_start;
    logic        stuck;
    logic [16:0] hold;
    logic        e_stuck;
    logic        e_to;
    logic [7:0]  e_cyc;
  } vec_t;

  localparam vec_t VECS[8] = '{
    '{1'b1, 1'b0, 17'd0,      1'b0, 1'b0, 8'(SU+4)},
    '{1'b0, 1'b0, 17'd0,      1'b0, 1'b0, 8'(SU+4)},
    '{1'b0, 1'b0, 17'd15,     1'b0, 1'b0, 8'd0},
    '{1'b0, 1'b0, 17'(FOREVER), 1'b0, 1'b1, 8'(TO+4)},
    '{1'b1, 1'b1, 17'd0,      1'b1, 1'b0, 8'd4},
    '{1'b1, 1'b0, 17'd20,     1'b0, 1'b0, 8'd0},
    '{1'b1, 1'b0, 17'(FOREVER), 1'b0, 1'b1, 8'(TO+4)},
    '{1'b0, 1'b0, 17'd30,     1'b0, 1'b0, 8'd0}
  };

  int done_cyc, sda_fall, scl_fall, ndone, err1_at;
  logic sda_before;

  task automatic run_op(input logic is_start, input logic also_rel, input int hold,
                        input logic stuck, input int late_rel);
    logic ps, pc;
    @(negedge clk);
    slave_sda_low = stuck;
    hold_until = cyc_ctr + hold;
    start_req = is_start;
    rel_req = !is_start || also_rel;
    ps = sda_oe; pc = scl_oe; sda_before = sda_oe;
    done_cyc = -1; sda_fall = -1; scl_fall = -1; ndone = 0; err1_at = -1;
    for (int c = 1; c < 500; c++) begin
      @(negedge clk);
      start_req = 1'b0;
      rel_req = (c == late_rel);
      if (c == 1) err1_at = int'(err_stuck) + int'(err_timeout);
      if (!ps && sda_oe && sda_fall < 0) sda_fall = c;
      if (!pc && scl_oe && scl_fall < 0) scl_fall = c;
      ps = sda_oe; pc = scl_oe;
      if (done) begin
        ndone++;
        if (done_cyc < 0) done_cyc = c;
      end
      if (done_cyc >= 0 && c >= done_cyc + 3) break;
    end
    rel_req = 1'b0;
  endtask

  initial begin
    int t0;
    t0 = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R11 reset state
    chk({sda_oe, scl_oe, done, busy, err_stuck, err_timeout} == 6'b0, "R11 reset outputs",
        {sda_oe, scl_oe, done, busy, err_stuck, err_timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[i]) begin
      run_op(VECS[i].is_start, 1'b0, int'(VECS[i].hold), VECS[i].stuck, -1);
      chk(ndone == 1, "R8 one done pulse", ndone, 1);
      chk(err1_at == 0, "R1 errors cleared on accept", err1_at, 0);
      chk(err_stuck == VECS[i].e_stuck, "R2 err_stuck", err_stuck, VECS[i].e_stuck);
      chk(err_timeout == VECS[i].e_to, "R4 err_timeout", err_timeout, VECS[i].e_to);
      if (VECS[i].e_cyc != 0)
        chk(done_cyc == int'(VECS[i].e_cyc), "R7 done latency", done_cyc, int'(VECS[i].e_cyc));
      if (VECS[i].e_stuck || VECS[i].e_to) begin
        chk(!sda_oe && !scl_oe, "R4 lines released after error", {sda_oe, scl_oe}, 0);
      end else begin
        chk(scl_oe, "R6 SCL pulled low at end", scl_oe, 1);
        if (VECS[i].is_start) begin
          chk(scl_fall - sda_fall == SU, "R5 SDA-to-SCL setup", scl_fall - sda_fall, SU);
          if (VECS[i].hold != 0)
            chk(done_cyc > SU + 4, "R3 stretch waited", done_cyc, SU + 5);
        end else begin
          chk(sda_oe == sda_before, "R6 SDA untouched by release", sda_oe, sda_before);
        end
      end
      slave_sda_low = 1'b0;
      hold_until = 0;
    end

    // R9 sticky error while idle, cleared by next request
    run_op(1'b1, 1'b0, 0, 1'b1, -1);
    slave_sda_low = 1'b0;
    repeat (6) @(negedge clk);
    chk(err_stuck && !err_timeout, "R9 error held while idle", err_stuck, 1);
    run_op(1'b1, 1'b0, 0, 1'b0, -1);
    chk(err1_at == 0 && !err_stuck, "R9 error cleared by next request", err_stuck, 0);

    // R10 simultaneous requests: start wins (SDA ends driven low)
    run_op(1'b0, 1'b0, FOREVER, 1'b0, -1);
    hold_until = 0;
    chk(!sda_oe, "R4 SDA free before combo test", sda_oe, 0);
    run_op(1'b1, 1'b1, 0, 1'b0, -1);
    chk(sda_oe && scl_oe, "R10 start wins over release", {sda_oe, scl_oe}, 3);
    chk(scl_fall - sda_fall == SU, "R10 start timing kept", scl_fall - sda_fall, SU);

    // R10 request during busy is ignored
    run_op(1'b1, 1'b0, 0, 1'b0, 2);
    repeat (12) @(negedge clk);
    chk(ndone == 1, "R10 busy request ignored (done count)", ndone, 1);
    chk(!busy, "R10 no second operation started", busy, 0);

    // R3 stretch near but below the timeout completes without error
    run_op(1'b0, 1'b0, TO - 8, 1'b0, -1);
    chk(!err_timeout && ndone == 1, "R3 long stretch within limit", err_timeout, 0);
    t0 = done_cyc;
    chk(t0 > SU + 4 && t0 < TO + 4 + SU, "R3 wait tracked SCL release", t0, TO);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule